// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This block sits between the register-read stage and the data memory port of a 32-bit core. It receives the values of up to two source registers, a signed 16-bit displacement, an addressing-mode select, an access size and an update flag. One clock edge later it presents the effective address, the byte enables and the lane-aligned write data for a big-endian 32-bit memory port. It also presents a load writeback port, whose data is the selected bytes of the memory read word with zero fill, and a separate base-register update port for the forms that write the computed address back.

The block detects the illegal encodings and reports them on an invalid-form flag. For every such request it suppresses the memory write, the load writeback and the update write. A base register numbered zero always contributes the value zero to the address, whatever value the register file supplies.

Top module: `lsEaUnit`

## Requirements
- R1: A request sampled with `reqValid` high at a rising edge raises `outValid` for exactly the following cycle, with all results registered at that edge. A cycle without a request gives `outValid`, `memWe`, `loadWe` and `updWe` all low.
- R2: With `mode` = 1 (base plus displacement), `memAddr` equals the base value plus `imm` sign-extended from 16 to 32 bits, modulo 2^32.
- R3: With `mode` = 0 (register indirect), `memAddr` equals the base value. With `mode` = 2 (indexed), `memAddr` equals the base value plus `indexVal`.
- R4: When `baseNum` is 0, the base contributes 0 in every mode, regardless of `baseVal`.
- R5: `size` selects 0 = byte, 1 = half-word, 2 = word. Memory is big-endian, and `memByteEn` bit 3 covers data bits 31:24, which hold address offset 0. A byte at offset k enables bit 3-k. A half-word enables 1100 when address bit 1 is 0 and 0011 when it is 1, ignoring address bit 0. A word enables 1111, ignoring the low two address bits.
- R6: A valid store raises `memWe`. The low 8 bits (byte) or low 16 bits (half-word) of `storeVal`, or all of it (word), are placed in the enabled lanes of `memWdata`, and the other lanes are zero. `memWdata` is zero when no store is issued.
- R7: A valid load raises `loadWe` with `loadNum` = `dstNum`. `loadData` holds the enabled lanes of `memRdata`, right-aligned and zero-extended, and follows `memRdata` combinationally during that cycle. `loadData` is zero when no load is issued.
- R8: A valid update form (`update` = 1 with mode 1 or 2) raises `updWe` with `updNum` = `baseNum` and `updData` = `memAddr`. For a load, this happens in the same cycle as `loadWe`.
- R9: A request is invalid when `mode` = 3, or `size` = 3, or it is an update with `mode` = 0, or an update with `baseNum` = 0, or a load update with `dstNum` = `baseNum`. An invalid request raises `invalidForm` and gives no `memWe`, `loadWe` or `updWe`.
- R10: While `rstN` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| isStore | input | 1 | 1 = store, 0 = load |
| update | input | 1 | Write the computed address back to the base register |
| mode | input | 2 | 0 indirect, 1 base plus displacement, 2 indexed, 3 reserved |
| size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| baseNum | input | 5 | Base register number |
| baseVal | input | 32 | Base register value from the register file |
| indexVal | input | 32 | Index register value |
| imm | input | 16 | Signed displacement |
| dstNum | input | 5 | Load destination register number |
| storeVal | input | 32 | Store source register value |
| memRdata | input | 32 | Memory read word for the access in the output cycle |
| outValid | output | 1 | Results valid |
| memAddr | output | 32 | Effective address |
| memByteEn | output | 4 | Byte enables, bit 3 = bits 31:24 |
| memWe | output | 1 | Memory write strobe |
| memWdata | output | 32 | Lane-aligned write data |
| loadWe | output | 1 | Load writeback strobe |
| loadNum | output | 5 | Load writeback register number |
| loadData | output | 32 | Zero-extended load data |
| updWe | output | 1 | Base update strobe |
| updNum | output | 5 | Base update register number |
| updData | output | 32 | Base update value |
| invalidForm | output | 1 | Illegal form detected |

## Verification
The address is tried with positive and negative displacements, with indexed sums, and with base register zero in both summing modes. These show whether the sign extension, the operand select and the zero-base rule are each applied. Byte, half-word and word accesses are placed at every byte offset, including offsets that are not aligned to the access size. This separates a correct big-endian lane choice from a little-endian or unmasked one, for both the store lanes and the load extraction. Each illegal combination is presented on its own next to a legal update of the same shape, so that an extra or missing term in the invalid check shows up as a suppressed or leaked write strobe.

// File: rtl/lsEaPkg.sv
package lsEaPkg;

  typedef enum logic [1:0] {
    AM_REG = 2'd0,
    AM_IMM = 2'd1,
    AM_IDX = 2'd2,
    AM_RSV = 2'd3
  } addrMode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSV  = 2'd3
  } accSize_e;

  // strobes from decode to the address datapath
  typedef struct packed {
    logic       accept;
    logic       zeroBase;
    logic       addImm;
    logic       addIndex;
    logic       doLoad;
    logic       doStore;
    logic       doUpdate;
    logic       invalid;
    logic [2:0] nBytes;
  } eaStrobe_t;

endpackage

// File: rtl/lsEaCtrl.sv
module lsEaCtrl
  import lsEaPkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             reqValid,
  input  logic             isStore,
  input  logic             update,
  input  logic [1:0]       mode,
  input  logic [1:0]       size,
  input  logic [REG_W-1:0] baseNum,
  input  logic [REG_W-1:0] dstNum,
  output eaStrobe_t        strobe
);

  addrMode_e modeSel;
  accSize_e  sizeSel;
  logic      baseIsZero;
  logic      badMode;
  logic      badSize;
  logic      badUpdate;
  logic      illegal;

  always_comb begin
    modeSel    = addrMode_e'(mode);
    sizeSel    = accSize_e'(size);
    baseIsZero = (baseNum == '0);
    badMode    = (modeSel == AM_RSV);
    badSize    = (sizeSel == SZ_RSV);
    badUpdate  = update && ((modeSel == AM_REG) || baseIsZero ||
                            (!isStore && (dstNum == baseNum)));
    illegal    = badMode || badSize || badUpdate;

    strobe          = '0;
    strobe.accept   = reqValid;
    strobe.zeroBase = baseIsZero;
    strobe.addImm   = (modeSel == AM_IMM);
    strobe.addIndex = (modeSel == AM_IDX);
    strobe.invalid  = reqValid && illegal;
    strobe.doLoad   = reqValid && !isStore && !illegal;
    strobe.doStore  = reqValid && isStore && !illegal;
    strobe.doUpdate = reqValid && update && !illegal;
    case (sizeSel)
      SZ_BYTE: strobe.nBytes = 3'd1;
      SZ_HALF: strobe.nBytes = 3'd2;
      default: strobe.nBytes = 3'd4;
    endcase
  end

endmodule

// File: rtl/lsEaDatapath.sv
module lsEaDatapath
  import lsEaPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int IMM_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  eaStrobe_t           strobe,
  input  logic [DATA_W-1:0]   baseVal,
  input  logic [DATA_W-1:0]   indexVal,
  input  logic [IMM_W-1:0]    imm,
  input  logic [REG_W-1:0]    baseNum,
  input  logic [REG_W-1:0]    dstNum,
  input  logic [DATA_W-1:0]   storeVal,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                outValid,
  output logic [DATA_W-1:0]   memAddr,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic                memWe,
  output logic [DATA_W-1:0]   memWdata,
  output logic                loadWe,
  output logic [REG_W-1:0]    loadNum,
  output logic [DATA_W-1:0]   loadData,
  output logic                updWe,
  output logic [REG_W-1:0]    updNum,
  output logic [DATA_W-1:0]   updData,
  output logic                invalidForm
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int CNT_W = OFF_W + 1;

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] effAddr;
  logic [CNT_W-1:0]  nb;
  logic [CNT_W-1:0]  offAligned;
  logic [CNT_W-1:0]  laneShift;
  logic [LANES-1:0]  beRaw;
  logic [LANES-1:0]  beNext;
  logic [DATA_W-1:0] valMask;
  logic [DATA_W-1:0] wdNext;
  logic [CNT_W-1:0]  shiftQ;
  logic [DATA_W-1:0] maskQ;

  // address arithmetic
  always_comb begin
    immExt  = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    opA     = strobe.zeroBase ? '0 : baseVal;
    if (strobe.addImm)        opB = immExt;
    else if (strobe.addIndex) opB = indexVal;
    else                      opB = '0;
    effAddr = opA + opB;
  end

  // big-endian lane placement
  always_comb begin
    nb         = CNT_W'(strobe.nBytes);
    offAligned = {1'b0, effAddr[OFF_W-1:0]} & ~(nb - CNT_W'(1));
    laneShift  = CNT_W'(LANES) - offAligned - nb;
    beRaw      = LANES'((1 << nb) - 1);
    beNext     = beRaw << laneShift;
    valMask    = DATA_W'((64'd1 << {nb, 3'b000}) - 64'd1);
    wdNext     = (storeVal & valMask) << {laneShift, 3'b000};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      memAddr     <= '0;
      memByteEn   <= '0;
      memWe       <= 1'b0;
      memWdata    <= '0;
      loadWe      <= 1'b0;
      loadNum     <= '0;
      shiftQ      <= '0;
      maskQ       <= '0;
      updWe       <= 1'b0;
      updNum      <= '0;
      updData     <= '0;
      invalidForm <= 1'b0;
    end else begin
      outValid    <= strobe.accept;
      memAddr     <= strobe.accept ? effAddr : '0;
      memByteEn   <= strobe.accept ? beNext : '0;
      memWe       <= strobe.doStore;
      memWdata    <= strobe.doStore ? wdNext : '0;
      loadWe      <= strobe.doLoad;
      loadNum     <= strobe.doLoad ? dstNum : '0;
      shiftQ      <= strobe.doLoad ? laneShift : '0;
      maskQ       <= strobe.doLoad ? valMask : '0;
      updWe       <= strobe.doUpdate;
      updNum      <= strobe.doUpdate ? baseNum : '0;
      updData     <= strobe.doUpdate ? effAddr : '0;
      invalidForm <= strobe.invalid;
    end
  end

  // load extraction stays combinational on the returning word
  always_comb begin
    loadData = (memRdata >> {shiftQ, 3'b000}) & maskQ;
  end

endmodule

// File: rtl/lsEaUnit.sv
module lsEaUnit
  import lsEaPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int IMM_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                isStore,
  input  logic                update,
  input  logic [1:0]          mode,
  input  logic [1:0]          size,
  input  logic [REG_W-1:0]    baseNum,
  input  logic [DATA_W-1:0]   baseVal,
  input  logic [DATA_W-1:0]   indexVal,
  input  logic [IMM_W-1:0]    imm,
  input  logic [REG_W-1:0]    dstNum,
  input  logic [DATA_W-1:0]   storeVal,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                outValid,
  output logic [DATA_W-1:0]   memAddr,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic                memWe,
  output logic [DATA_W-1:0]   memWdata,
  output logic                loadWe,
  output logic [REG_W-1:0]    loadNum,
  output logic [DATA_W-1:0]   loadData,
  output logic                updWe,
  output logic [REG_W-1:0]    updNum,
  output logic [DATA_W-1:0]   updData,
  output logic                invalidForm
);

  eaStrobe_t strobe;

  lsEaCtrl #(.REG_W(REG_W)) uCtrl (
    .reqValid (reqValid),
    .isStore  (isStore),
    .update   (update),
    .mode     (mode),
    .size     (size),
    .baseNum  (baseNum),
    .dstNum   (dstNum),
    .strobe   (strobe)
  );

  lsEaDatapath #(.DATA_W(DATA_W), .REG_W(REG_W), .IMM_W(IMM_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .baseVal     (baseVal),
    .indexVal    (indexVal),
    .imm         (imm),
    .baseNum     (baseNum),
    .dstNum      (dstNum),
    .storeVal    (storeVal),
    .memRdata    (memRdata),
    .outValid    (outValid),
    .memAddr     (memAddr),
    .memByteEn   (memByteEn),
    .memWe       (memWe),
    .memWdata    (memWdata),
    .loadWe      (loadWe),
    .loadNum     (loadNum),
    .loadData    (loadData),
    .updWe       (updWe),
    .updNum      (updNum),
    .updData     (updData),
    .invalidForm (invalidForm)
  );

endmodule

// File: rtl/lsEaUnitChk.sv
module lsEaUnitChk #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int IMM_W  = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                isStore,
  input logic                update,
  input logic [1:0]          mode,
  input logic [1:0]          size,
  input logic [REG_W-1:0]    baseNum,
  input logic [DATA_W-1:0]   baseVal,
  input logic [DATA_W-1:0]   indexVal,
  input logic [IMM_W-1:0]    imm,
  input logic [REG_W-1:0]    dstNum,
  input logic [DATA_W-1:0]   storeVal,
  input logic [DATA_W-1:0]   memRdata,
  input logic                outValid,
  input logic [DATA_W-1:0]   memAddr,
  input logic [DATA_W/8-1:0] memByteEn,
  input logic                memWe,
  input logic [DATA_W-1:0]   memWdata,
  input logic                loadWe,
  input logic [REG_W-1:0]    loadNum,
  input logic [DATA_W-1:0]   loadData,
  input logic                updWe,
  input logic [REG_W-1:0]    updNum,
  input logic [DATA_W-1:0]   updData,
  input logic                invalidForm
);

  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] laneMask;
  always_comb begin
    for (int j = 0; j < LANES; j++) laneMask[8*j +: 8] = {8{memByteEn[j]}};
  end

  // R1
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(reqValid));

  // R1
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!memWe && !loadWe && !updWe));

  // R4
  zero_base_indirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(mode) == 2'd0 && $past(baseNum) == '0) |-> memAddr == '0);

  // R5
  byte_enable_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($countones(memByteEn) == 1 || $countones(memByteEn) == 2 ||
                  $countones(memByteEn) == 4));

  // R6
  store_lane_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ((memWdata & ~laneMask) == '0));

  // R8
  update_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    updWe |-> (updNum == $past(baseNum) && updData == memAddr && updNum != '0));

  // R9
  invalid_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    invalidForm |-> (!memWe && !loadWe && !updWe));

  // R9
  dual_write_distinct_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadWe && updWe) |-> (loadNum != updNum));

endmodule

bind lsEaUnit lsEaUnitChk #(.DATA_W(DATA_W), .REG_W(REG_W), .IMM_W(IMM_W)) uChk (.*);

// File: tb/sim_lsEaUnit.sv
module sim_lsEaUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        isStore = 1'b0;
  logic        update = 1'b0;
  logic [1:0]  mode = '0;
  logic [1:0]  size = '0;
  logic [4:0]  baseNum = '0;
  logic [31:0] baseVal = '0;
  logic [31:0] indexVal = '0;
  logic [15:0] imm = '0;
  logic [4:0]  dstNum = '0;
  logic [31:0] storeVal = '0;
  logic [31:0] memRdata = '0;
  logic        outValid;
  logic [31:0] memAddr;
  logic [3:0]  memByteEn;
  logic        memWe;
  logic [31:0] memWdata;
  logic        loadWe;
  logic [4:0]  loadNum;
  logic [31:0] loadData;
  logic        updWe;
  logic [4:0]  updNum;
  logic [31:0] updData;
  logic        invalidForm;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lsEaUnit u0 (.*);

  typedef struct packed {
    logic        isSt;
    logic [1:0]  md;
    logic        up;
    logic [1:0]  sz;
    logic [4:0]  bNum;
    logic [31:0] bVal;
    logic [31:0] xVal;
    logic [15:0] im;
    logic [4:0]  dNum;
    logic [31:0] eAddr;
    logic [3:0]  eBe;
    logic        eWe;
    logic [31:0] eWd;
    logic        eLwe;
    logic [31:0] eLd;
    logic        eUwe;
    logic        eInv;
  } vec_t;

  localparam logic [31:0] RD = 32'hA1B2_C3D4;
  localparam logic [31:0] SV = 32'h5566_7788;
  localparam int NV = 19;

  localparam vec_t VECS [NV] = '{
    // 0 R3 indirect word load
    '{1'b0,2'd0,1'b0,2'd2,5'd3,32'h1000,32'h0,16'h0,5'd4,32'h1000,4'hF,1'b0,32'h0,1'b1,RD,1'b0,1'b0},
    // 1 R2 R5 byte offset 1
    '{1'b0,2'd1,1'b0,2'd0,5'd5,32'h2000,32'h0,16'h0005,5'd1,32'h2005,4'h4,1'b0,32'h0,1'b1,32'hB2,1'b0,1'b0},
    // 2 R2 negative displacement, byte offset 3
    '{1'b0,2'd1,1'b0,2'd0,5'd5,32'h2000,32'h0,16'hFFFF,5'd1,32'h1FFF,4'h1,1'b0,32'h0,1'b1,32'hD4,1'b0,1'b0},
    // 3 R4 zero base with displacement
    '{1'b0,2'd1,1'b0,2'd2,5'd0,32'hDEADBEEF,32'h0,16'h0010,5'd6,32'h10,4'hF,1'b0,32'h0,1'b1,RD,1'b0,1'b0},
    // 4 R3 indexed half at offset 2
    '{1'b0,2'd2,1'b0,2'd1,5'd2,32'h100,32'h22,16'h0,5'd7,32'h122,4'h3,1'b0,32'h0,1'b1,32'hC3D4,1'b0,1'b0},
    // 5 R4 zero base indexed
    '{1'b0,2'd2,1'b0,2'd2,5'd0,32'h999,32'h40,16'h0,5'd7,32'h40,4'hF,1'b0,32'h0,1'b1,RD,1'b0,1'b0},
    // 6 R6 R8 half store with update
    '{1'b1,2'd1,1'b1,2'd1,5'd9,32'h3000,32'h0,16'h0002,5'd10,32'h3002,4'h3,1'b1,32'h0000_7788,1'b0,32'h0,1'b1,1'b0},
    // 7 R6 byte store offset 0
    '{1'b1,2'd2,1'b0,2'd0,5'd4,32'h400,32'h4,16'h0,5'd0,32'h404,4'h8,1'b1,32'h8800_0000,1'b0,32'h0,1'b0,1'b0},
    // 8 R8 indexed word store with update
    '{1'b1,2'd2,1'b1,2'd2,5'd6,32'h500,32'h20,16'h0,5'd0,32'h520,4'hF,1'b1,SV,1'b0,32'h0,1'b1,1'b0},
    // 9 R9 load update, destination equals base
    '{1'b0,2'd1,1'b1,2'd2,5'd8,32'h800,32'h0,16'h0004,5'd8,32'h804,4'hF,1'b0,32'h0,1'b0,32'h0,1'b0,1'b1},
    // 10 R9 update with base 0
    '{1'b1,2'd1,1'b1,2'd2,5'd0,32'h777,32'h0,16'h0008,5'd0,32'h8,4'hF,1'b0,32'h0,1'b0,32'h0,1'b0,1'b1},
    // 11 R8 load update, both write ports
    '{1'b0,2'd1,1'b1,2'd1,5'd8,32'h800,32'h0,16'hFFFC,5'd3,32'h7FC,4'hC,1'b0,32'h0,1'b1,32'hA1B2,1'b1,1'b0},
    // 12 R9 reserved mode
    '{1'b0,2'd3,1'b0,2'd2,5'd1,32'h10,32'h0,16'h0,5'd2,32'h10,4'hF,1'b0,32'h0,1'b0,32'h0,1'b0,1'b1},
    // 13 R9 update in indirect mode
    '{1'b0,2'd0,1'b1,2'd2,5'd1,32'h10,32'h0,16'h0,5'd2,32'h10,4'hF,1'b0,32'h0,1'b0,32'h0,1'b0,1'b1},
    // 14 R6 half store offset 0
    '{1'b1,2'd1,1'b0,2'd1,5'd3,32'h600,32'h0,16'h0,5'd0,32'h600,4'hC,1'b1,32'h7788_0000,1'b0,32'h0,1'b0,1'b0},
    // 15 R6 byte store offset 2
    '{1'b1,2'd0,1'b0,2'd0,5'd3,32'h602,32'h0,16'h0,5'd0,32'h602,4'h2,1'b1,32'h0000_8800,1'b0,32'h0,1'b0,1'b0},
    // 16 R9 reserved size
    '{1'b0,2'd0,1'b0,2'd3,5'd1,32'h20,32'h0,16'h0,5'd2,32'h20,4'hF,1'b0,32'h0,1'b0,32'h0,1'b0,1'b1},
    // 17 R5 word ignores low address bits
    '{1'b0,2'd0,1'b0,2'd2,5'd1,32'h1003,32'h0,16'h0,5'd2,32'h1003,4'hF,1'b0,32'h0,1'b1,RD,1'b0,1'b0},
    // 18 R5 half ignores address bit 0
    '{1'b0,2'd0,1'b0,2'd1,5'd1,32'h1001,32'h0,16'h0,5'd2,32'h1001,4'hC,1'b0,32'h0,1'b1,32'hA1B2,1'b0,1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    reqValid = 1'b1;
    isStore  = v.isSt;
    mode     = v.md;
    update   = v.up;
    size     = v.sz;
    baseNum  = v.bNum;
    baseVal  = v.bVal;
    indexVal = v.xVal;
    imm      = v.im;
    dstNum   = v.dNum;
    storeVal = SV;
    memRdata = RD;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    // R10 reset state, with a request held during reset
    reqValid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 outValid", {31'b0, outValid}, 32'h0);
    chk("R10 memAddr", memAddr, 32'h0);
    chk("R10 strobes", {28'b0, memWe, loadWe, updWe, invalidForm}, 32'h0);
    reqValid = 1'b0;
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R1 idle cycle
    chk("R1 idle outValid", {31'b0, outValid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R1 v%0d outValid", i), {31'b0, outValid}, 32'h1);
      chk($sformatf("R2 v%0d memAddr", i), memAddr, VECS[i].eAddr);
      chk($sformatf("R5 v%0d memByteEn", i), {28'b0, memByteEn}, {28'b0, VECS[i].eBe});
      chk($sformatf("R6 v%0d memWe", i), {31'b0, memWe}, {31'b0, VECS[i].eWe});
      chk($sformatf("R6 v%0d memWdata", i), memWdata, VECS[i].eWd);
      chk($sformatf("R7 v%0d loadWe", i), {31'b0, loadWe}, {31'b0, VECS[i].eLwe});
      chk($sformatf("R7 v%0d loadData", i), loadData, VECS[i].eLd);
      if (VECS[i].eLwe)
        chk($sformatf("R7 v%0d loadNum", i), {27'b0, loadNum}, {27'b0, VECS[i].dNum});
      chk($sformatf("R8 v%0d updWe", i), {31'b0, updWe}, {31'b0, VECS[i].eUwe});
      if (VECS[i].eUwe) begin
        chk($sformatf("R8 v%0d updNum", i), {27'b0, updNum}, {27'b0, VECS[i].bNum});
        chk($sformatf("R8 v%0d updData", i), updData, VECS[i].eAddr);
      end
      chk($sformatf("R9 v%0d invalidForm", i), {31'b0, invalidForm}, {31'b0, VECS[i].eInv});
    end

    // R1 one-cycle pulse: request then idle
    reqValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 pulse ends", {31'b0, outValid}, 32'h0);
    chk("R1 idle strobes", {29'b0, memWe, loadWe, updWe}, 32'h0);

    // R7 load data follows memRdata combinationally in the output cycle
    drive(VECS[1]);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    memRdata = 32'h0077_0000;
    #1;
    chk("R7 live loadData", loadData, 32'h77);

    // R3 indexed with wrapping sum
    drive(VECS[4]);
    baseVal  = 32'hFFFF_FFF0;
    indexVal = 32'h0000_0014;
    @(posedge clk);
    @(negedge clk);
    chk("R3 wrap memAddr", memAddr, 32'h4);

    // R2 most negative displacement
    drive(VECS[1]);
    size = 2'd2;
    imm  = 16'h8000;
    @(posedge clk);
    @(negedge clk);
    chk("R2 min disp memAddr", memAddr, 32'h2000 - 32'h8000);

    reqValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule